// File: doc/BRIEF.md
# Line Transceiver Control Sequencer

This block is the digital control core of the master end of a burst line transceiver. It runs on the internal sequencing clock. It brings the system sync input and the mode and signaling inputs into that clock through two flip-flop stages. It then works out when the modulator may send and when received signaling bits reach the outputs. The modulator, the demodulator and the analog line interface sit outside the block and are seen only as strobes: `tx_start` asks for a burst, and `demod_done` reports the end of a received one.

The control inputs can be shared with other transceivers on a common bus. While the bus enable is low, the block keeps the last power, loopback, signaling and insert settings it saw. It also drops the output enable, so that its received-bit outputs can be treated as high impedance. The moment at which received bits reach the outputs depends on the power state. While powered up, they change on a sync rising edge. While powered down, they change as soon as a burst has been demodulated. After power-up, the block waits a set number of sync edges, or until a burst arrives, before it starts sending.

Top module: `line_ctl_seq`

## Requirements
- R1: After reset, `out_oe`, `tx_start`, `so_a`, `so_b`, `vd` and `loop_act` are all 0, and the block is powered down.
- R2: While the synchronised `sig_en_in` is low, `out_oe` is 0. Changes on `pd_n_in`, `lb_n_in`, `si_a_in`, `si_b_in` and `ins_en_in` have no effect until `sig_en_in` returns high.
- R3: While transmitting, each sync rising edge copies the held `si_a_in` and `si_b_in` values to `tx_sig_a` and `tx_sig_b` in the same cycle as `tx_start`.
- R4: While powered up (`pd_n_in` = 1), a finished burst changes nothing at `so_a`, `so_b` and `vd` until the next sync rising edge. On that edge its values appear.
- R5: While powered down (`pd_n_in` = 0), `so_a`, `so_b` and `vd` take the burst's values in the clock after the `demod_done` strobe.
- R6: For each burst, `vd` is 1 only when `rx_sync_ok` = 1 and `rx_err` = 0.
- R7: While powered down, no `tx_start` pulse is issued and `tx_sig_a` and `tx_sig_b` do not change.
- R8: After power-up, the first WAIT_EDGES (default 3) sync rising edges produce no `tx_start`. Every later sync rising edge produces one `tx_start` pulse, one clock long.
- R9: A `demod_done` strobe during the power-up wait ends the wait, and the next sync rising edge produces `tx_start`.
- R10: `loop_act` is 1 only while `lb_n_in` = 0 and the block is powered up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sequencing clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sync_in | input | 1 | System sync, asynchronous |
| sig_en_in | input | 1 | Bus enable; low freezes inputs and disables outputs |
| pd_n_in | input | 1 | Power control, low = powered down |
| lb_n_in | input | 1 | Loopback request, active low |
| si_a_in | input | 1 | Signaling bit A to send |
| si_b_in | input | 1 | Signaling bit B to send |
| ins_en_in | input | 1 | Insert-enable mode input |
| demod_done | input | 1 | One-clock strobe at the end of a received burst |
| rx_bit_a | input | 1 | Received signaling bit A, valid with `demod_done` |
| rx_bit_b | input | 1 | Received signaling bit B, valid with `demod_done` |
| rx_sync_ok | input | 1 | Burst sync found correct, valid with `demod_done` |
| rx_err | input | 1 | Bit error detected, valid with `demod_done` |
| tx_start | output | 1 | One-clock request to send a burst |
| tx_sig_a | output | 1 | Signaling bit A latched for sending |
| tx_sig_b | output | 1 | Signaling bit B latched for sending |
| tx_ins_en | output | 1 | Held insert-enable mode |
| loop_act | output | 1 | Internal loopback active |
| so_a | output | 1 | Received signaling bit A |
| so_b | output | 1 | Received signaling bit B |
| vd | output | 1 | Received burst valid |
| out_oe | output | 1 | Output enable for `so_a`, `so_b`, `vd` |

## Verification
The assertions assume that `demod_done` is a one-clock strobe in the clock domain. They also assume that `rx_*` are valid in the same cycle as that strobe and that a sync high or low phase lasts longer than the two-stage synchroniser. The bench drives sync as pulses several clocks wide. It raises `demod_done` for exactly one cycle, always away from a sync edge. It waits six clocks after each control change, so that every check sees settled, synchronised values.

// File: rtl/line_ctl_seq.sv
module line_ctl_seq #(
  parameter int WAIT_EDGES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_in,
  input  logic sig_en_in,
  input  logic pd_n_in,
  input  logic lb_n_in,
  input  logic si_a_in,
  input  logic si_b_in,
  input  logic ins_en_in,
  input  logic demod_done,
  input  logic rx_bit_a,
  input  logic rx_bit_b,
  input  logic rx_sync_ok,
  input  logic rx_err,
  output logic tx_start,
  output logic tx_sig_a,
  output logic tx_sig_b,
  output logic tx_ins_en,
  output logic loop_act,
  output logic so_a,
  output logic so_b,
  output logic vd,
  output logic out_oe
);
  localparam int CW = $clog2(WAIT_EDGES + 1);
  localparam logic [6:0] RAW_RST = 7'b000_1000;

  typedef enum logic [1:0] {P_OFF, P_WAIT, P_RUN} pwr_t;

  logic [6:0] raw, s1, s2;
  logic       sync_d, sync_rise, en_s;
  logic       pd_h, lb_h, sa_h, sb_h, ins_h;
  pwr_t       st;
  logic [CW-1:0] edges;
  logic       pend_a, pend_b, pend_v, rx_good;

  assign raw = {sync_in, sig_en_in, pd_n_in, lb_n_in, si_a_in, si_b_in, ins_en_in};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= RAW_RST;
      s2 <= RAW_RST;
      sync_d <= 1'b0;
    end else begin
      s1 <= raw;
      s2 <= s1;
      sync_d <= s2[6];
    end

  assign sync_rise = s2[6] & ~sync_d;
  assign en_s      = s2[5];
  assign out_oe    = en_s;
  assign tx_ins_en = ins_h;
  assign rx_good   = rx_sync_ok & ~rx_err;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {pd_h, lb_h, sa_h, sb_h, ins_h} <= 5'b01000;
    else if (en_s) {pd_h, lb_h, sa_h, sb_h, ins_h} <= s2[4:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= P_OFF;
      edges <= '0;
    end else if (!pd_h) begin
      st <= P_OFF;
      edges <= '0;
    end else begin
      case (st)
        P_OFF: begin
          st <= P_WAIT;
          edges <= '0;
        end
        P_WAIT:
          if (demod_done) st <= P_RUN;
          else if (sync_rise) begin
            if (edges == CW'(WAIT_EDGES - 1)) st <= P_RUN;
            edges <= edges + 1'b1;
          end
        default: st <= P_RUN;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_start <= 1'b0;
      tx_sig_a <= 1'b0;
      tx_sig_b <= 1'b0;
      loop_act <= 1'b0;
    end else begin
      tx_start <= (st == P_RUN) && sync_rise;
      if ((st == P_RUN) && sync_rise) begin
        tx_sig_a <= sa_h;
        tx_sig_b <= sb_h;
      end
      loop_act <= pd_h & ~lb_h;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      {pend_a, pend_b, pend_v} <= 3'b000;
      {so_a, so_b, vd} <= 3'b000;
    end else if (pd_h) begin
      if (demod_done) {pend_a, pend_b, pend_v} <= {rx_bit_a, rx_bit_b, rx_good};
      if (sync_rise) {so_a, so_b, vd} <= {pend_a, pend_b, pend_v};
    end else if (demod_done) begin
      {so_a, so_b, vd} <= {rx_bit_a, rx_bit_b, rx_good};
    end

  AST_FROZEN_WHEN_OFFBUS: assert property (@(posedge clk) disable iff (!rst_n)
    !en_s |=> $stable({pd_h, lb_h, sa_h, sb_h, ins_h})); // R2
  AST_NO_TX_POWERED_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (st == P_OFF) |=> !tx_start); // R7
  AST_TX_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> !tx_start); // R8
  AST_BAD_BURST_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    (demod_done && !pd_h && !rx_good) |=> !vd); // R6
  AST_LOOP_NEEDS_POWER: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_h |=> !loop_act); // R10
  AST_HOLD_TX_SIG_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (st == P_OFF) |=> $stable({tx_sig_a, tx_sig_b})); // R7
endmodule

// File: tb/sim_line_ctl_seq.sv
module sim_line_ctl_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sync_in = 0, sig_en_in = 0, pd_n_in = 0, lb_n_in = 1;
  logic si_a_in = 0, si_b_in = 0, ins_en_in = 0;
  logic demod_done = 0, rx_bit_a = 0, rx_bit_b = 0, rx_sync_ok = 0, rx_err = 0;
  logic tx_start, tx_sig_a, tx_sig_b, tx_ins_en, loop_act, so_a, so_b, vd, out_oe;
  int tests = 0, fails = 0, tx_cnt = 0, base = 0;
  logic [2:0] exp_so;

  always #10 clk = ~clk;

  line_ctl_seq u0 (.*);

  always @(posedge clk) if (tx_start) tx_cnt <= tx_cnt + 1;

  function automatic logic [2:0] burst_val(logic a, logic b, logic ok, logic er);
    return {a, b, ok & ~er};
  endfunction

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic pulse();
    @(negedge clk) sync_in = 1;
    repeat (4) @(negedge clk);
    sync_in = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic burst(logic a, logic b, logic ok, logic er);
    @(negedge clk);
    {rx_bit_a, rx_bit_b, rx_sync_ok, rx_err} = {a, b, ok, er};
    demod_done = 1;
    @(negedge clk) demod_done = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1 out_oe", out_oe, 0);
    chk("R1 tx_start", tx_start, 0);
    chk("R1 so/vd", {so_a, so_b, vd}, 0);
    chk("R1 loop_act", loop_act, 0);
    rst_n = 1;
    sig_en_in = 1;
    settle();
    chk("R2 out_oe high", out_oe, 1);
    // R5 powered down: outputs follow burst right away, random patterns
    for (int i = 0; i < 6; i++) begin
      logic [3:0] r = 4'($urandom);
      burst(r[3], r[2], r[1], r[0]);
      chk("R5/R6 down update", {so_a, so_b, vd}, burst_val(r[3], r[2], r[1], r[0]));
    end
    pulse();
    chk("R7 no tx powered down", tx_cnt, 0);
    // R8 power up wait
    pd_n_in = 1;
    settle();
    pulse(); pulse(); pulse();
    chk("R8 no tx during wait", tx_cnt, 0);
    pulse();
    chk("R8 first tx", tx_cnt, 1);
    pulse();
    chk("R8 tx every period", tx_cnt, 2);
    // R3 signaling latch
    for (int i = 0; i < 6; i++) begin
      logic [1:0] r = 2'($urandom);
      {si_a_in, si_b_in} = r;
      settle();
      pulse();
      chk("R3 tx_sig", {tx_sig_a, tx_sig_b}, r);
    end
    // R4 powered up: held until sync
    exp_so = {so_a, so_b, vd};
    for (int i = 0; i < 6; i++) begin
      logic [3:0] r = 4'($urandom);
      burst(r[3], r[2], r[1], r[0]);
      chk("R4 hold until sync", {so_a, so_b, vd}, exp_so);
      pulse();
      exp_so = burst_val(r[3], r[2], r[1], r[0]);
      chk("R4/R6 update on sync", {so_a, so_b, vd}, exp_so);
    end
    burst(1, 1, 1, 1);
    pulse();
    chk("R6 error burst invalid", vd, 0);
    burst(1, 1, 0, 0);
    pulse();
    chk("R6 bad sync invalid", vd, 0);
    // R10 loopback
    lb_n_in = 0;
    settle();
    chk("R10 loop on", loop_act, 1);
    pd_n_in = 0;
    settle();
    chk("R10 loop off when down", loop_act, 0);
    lb_n_in = 1;
    // R7 signaling frozen while down
    {si_a_in, si_b_in} = ~{tx_sig_a, tx_sig_b};
    exp_so[1:0] = {tx_sig_a, tx_sig_b};
    base = tx_cnt;
    settle();
    pulse();
    chk("R7 tx_sig held", {tx_sig_a, tx_sig_b}, exp_so[1:0]);
    chk("R7 no tx", tx_cnt, base);
    // R9 early exit on burst
    pd_n_in = 1;
    settle();
    pulse();
    burst(0, 1, 1, 0);
    base = tx_cnt;
    pulse();
    chk("R9 tx after burst", tx_cnt, base + 1);
    // R2 bus-share window
    sig_en_in = 0;
    settle();
    chk("R2 out_oe low", out_oe, 0);
    exp_so[1:0] = {tx_sig_a, tx_sig_b};
    {si_a_in, si_b_in} = ~exp_so[1:0];
    lb_n_in = 0;
    pd_n_in = 0;
    settle();
    base = tx_cnt;
    pulse();
    chk("R2 si frozen", {tx_sig_a, tx_sig_b}, exp_so[1:0]);
    chk("R2 pd frozen", tx_cnt, base + 1);
    chk("R2 lb frozen", loop_act, 0);
    sig_en_in = 1;
    settle();
    base = tx_cnt;
    pulse();
    chk("R7 down after enable", tx_cnt, base);
    chk("R2 out_oe restored", out_oe, 1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule